// File: doc/BRIEF.md
# Burst Bus-Invert Link with Flag Cycle

This block carries polarity-encoded bytes across a narrow on-chip bus without a dedicated invert wire. On the transmit side, a framer accepts one byte and one invert flag per handshake. It places either the byte or its complement on the bus. After every eight data beats it inserts one extra beat that carries the eight flags of that burst. The choice of when to invert is made upstream and arrives as the per-word flag.

On the receive side, a deframer collects the eight bus words of a burst in a small buffer and holds them back until the flag beat has been taken. It then releases the words in arrival order, each one XORed with its own flag bit replicated across the byte, so the consumer sees exactly the bytes the producer offered. Both the producer and consumer sides use valid/ready handshakes. The bus between the two halves has a valid/ready pair of its own, so a busy deframer holds the framer off.

The bus word and its handshake are brought out as ports so that the encoded traffic can be observed.

Top module: `ibl_link`

## Requirements
- R1: For data beat k of a burst, the bus carries the input byte when its flag is 0 and the bitwise complement of the byte when its flag is 1.
- R2: After the eighth data beat of a burst, the next bus beat is a flag byte whose bit k (bit 0 = first word) equals the flag of word k of that burst.
- R3: In the cycle after the eighth word of a burst is accepted, `in_ready` is low, so no input is taken while the flag beat is pending.
- R4: `out_data` delivers every accepted input byte, unchanged and in input order.
- R5: No word of a burst appears on `out_valid` before the flag beat of that burst has been transferred on the bus.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value.
- R7: Synchronous active-high reset drives `in_ready` high and `bus_valid` and `out_valid` low, and discards a partially received burst, so none of its words is ever output.
- R8: While `bus_valid` is high and `bus_ready` is low, `bus_valid` stays high and `bus_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Producer offers a byte |
| in_ready | output | 1 | Framer takes the byte this cycle |
| in_data | input | DW | Byte to send |
| in_flip | input | 1 | Send this byte complemented |
| bus_valid | output | 1 | Bus beat present |
| bus_data | output | DW | Encoded bus word or flag byte |
| bus_ready | output | 1 | Deframer takes the bus beat |
| out_valid | output | 1 | Restored byte available |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | DW | Restored byte |

## Verification
The bench builds the block with its default 8-bit word and 8-word burst. At that size, 256 consecutive bursts can use every possible flag byte as their invert pattern, while the data bytes run through every byte value eight times. Each bus beat and each output byte is checked against values derived from the burst and word index. Irregular consumer stalls and producer gaps force both the link hold-off and the output hold paths. A reset issued in the middle of a burst confirms that the partial words are dropped.

// File: rtl/ibl_pkg.sv
package ibl_pkg;
  localparam int unsigned IBL_DW    = 8;
  localparam int unsigned IBL_BURST = 8;
endpackage

// File: rtl/ibl_framer.sv
module ibl_framer #(
  parameter int unsigned DW    = ibl_pkg::IBL_DW,
  parameter int unsigned BURST = ibl_pkg::IBL_BURST,
  localparam int unsigned PW   = $clog2(BURST + 1),
  localparam int unsigned IW   = $clog2(BURST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_flip,
  output logic          bus_valid,
  output logic [DW-1:0] bus_data,
  input  logic          bus_ready,
  output logic [PW-1:0] pos_o
);
  localparam logic [PW-1:0] FLAG_POS = PW'(BURST);

  logic [PW-1:0]    pos;
  logic [BURST-1:0] flags;
  logic             bvld;
  logic [DW-1:0]    bdat;
  logic             adv;
  logic             take;

  // The output register may be reloaded when empty or being drained.
  assign adv      = !bvld || bus_ready;
  assign in_ready = (pos != FLAG_POS) && adv;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      flags <= '0;
      bvld  <= 1'b0;
      bdat  <= '0;
    end else if (adv) begin
      if (pos == FLAG_POS) begin
        bvld <= 1'b1;
        bdat <= DW'(flags);
        pos  <= '0;
      end else if (take) begin
        bvld                <= 1'b1;
        bdat                <= in_data ^ {DW{in_flip}};
        flags[pos[IW-1:0]]  <= in_flip;
        pos                 <= pos + 1'b1;
      end else begin
        bvld <= 1'b0;
      end
    end
  end

  assign bus_valid = bvld;
  assign bus_data  = bdat;
  assign pos_o     = pos;
endmodule

// File: rtl/ibl_deframer.sv
module ibl_deframer #(
  parameter int unsigned DW    = ibl_pkg::IBL_DW,
  parameter int unsigned BURST = ibl_pkg::IBL_BURST,
  localparam int unsigned PW   = $clog2(BURST + 1),
  localparam int unsigned IW   = $clog2(BURST)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_valid,
  input  logic [DW-1:0] bus_data,
  output logic          bus_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [PW-1:0] pos_o,
  output logic          drain_o
);
  localparam logic [PW-1:0] FLAG_POS = PW'(BURST);
  localparam logic [IW-1:0] LAST_IDX = IW'(BURST - 1);

  logic [DW-1:0]    mem [BURST];
  logic [PW-1:0]    pos;
  logic [BURST-1:0] flags;
  logic             drain;
  logic [IW-1:0]    idx;
  logic             ovld;
  logic [DW-1:0]    odat;
  logic             acc;
  logic             load;
  logic [DW-1:0]    rd;
  logic [DW-1:0]    restored;

  assign bus_ready = !drain;
  assign acc       = bus_valid && !drain;
  assign load      = drain && (!ovld || out_ready);

  // Storage has no reset so it maps onto distributed or block memory.
  always_ff @(posedge clk) begin
    if (acc && (pos != FLAG_POS)) mem[pos[IW-1:0]] <= bus_data;
  end

  assign rd = mem[idx];

  for (genvar b = 0; b < DW; b++) begin : g_restore
    assign restored[b] = rd[b] ^ flags[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      flags <= '0;
      drain <= 1'b0;
      idx   <= '0;
      ovld  <= 1'b0;
      odat  <= '0;
    end else begin
      if (acc) begin
        if (pos == FLAG_POS) begin
          flags <= bus_data[BURST-1:0];
          drain <= 1'b1;
          idx   <= '0;
          pos   <= '0;
        end else begin
          pos <= pos + 1'b1;
        end
      end
      if (load) begin
        ovld <= 1'b1;
        odat <= restored;
        idx  <= idx + 1'b1;
        if (idx == LAST_IDX) drain <= 1'b0;
      end else if (out_ready) begin
        ovld <= 1'b0;
      end
    end
  end

  assign out_valid = ovld;
  assign out_data  = odat;
  assign pos_o     = pos;
  assign drain_o   = drain;
endmodule

// File: rtl/ibl_link.sv
module ibl_link #(
  parameter int unsigned DW    = ibl_pkg::IBL_DW,
  parameter int unsigned BURST = ibl_pkg::IBL_BURST
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_flip,
  output logic          bus_valid,
  output logic [DW-1:0] bus_data,
  output logic          bus_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int unsigned PW = $clog2(BURST + 1);

  logic [PW-1:0] tx_pos;
  logic [PW-1:0] rx_pos;
  logic          rx_drain;

  ibl_framer #(.DW(DW), .BURST(BURST)) u_tx (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_flip(in_flip),
    .bus_valid(bus_valid), .bus_data(bus_data), .bus_ready(bus_ready),
    .pos_o(tx_pos)
  );

  ibl_deframer #(.DW(DW), .BURST(BURST)) u_rx (
    .clk(clk), .rst(rst),
    .bus_valid(bus_valid), .bus_data(bus_data), .bus_ready(bus_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .pos_o(rx_pos), .drain_o(rx_drain)
  );
endmodule

// File: rtl/ibl_link_chk.sv
module ibl_link_chk #(
  parameter int unsigned DW    = 8,
  parameter int unsigned BURST = 8,
  localparam int unsigned PW   = $clog2(BURST + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          in_ready,
  input logic          bus_valid,
  input logic [DW-1:0] bus_data,
  input logic          bus_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic [PW-1:0] tx_pos,
  input logic [PW-1:0] rx_pos,
  input logic          rx_drain
);
  localparam logic [PW-1:0] LAST = PW'(BURST);

  AST_FLAG_STALL: assert property (@(posedge clk) disable iff (rst)
    (tx_pos == LAST) |-> !in_ready);                                   // R3
  AST_TX_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    tx_pos <= LAST);                                                   // R2
  AST_RX_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    rx_pos <= LAST);                                                   // R5
  AST_OUT_AFTER_FLAGS: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(rx_drain));                             // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));   // R6
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data)));   // R8
endmodule

bind ibl_link ibl_link_chk #(.DW(DW), .BURST(BURST)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready),
  .bus_valid(bus_valid), .bus_data(bus_data), .bus_ready(bus_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .tx_pos(tx_pos), .rx_pos(rx_pos), .rx_drain(rx_drain)
);

// File: tb/tb_ibl_link.sv
`timescale 1ns/100ps
module tb_ibl_link;
  localparam int DW = 8;
  localparam int NB = 256;
  localparam int NW = NB * 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [DW-1:0] in_data = '0;
  logic in_flip = 1'b0;
  logic bus_valid, bus_ready, out_valid;
  logic [DW-1:0] bus_data, out_data;
  logic out_ready = 1'b1;

  int checks = 0, fails = 0;
  int bi = 0, oi = 0, cyc = 0;
  bit mon_en = 1'b0, done = 1'b0;
  bit prev_ostall = 1'b0, prev_bstall = 1'b0;
  logic [DW-1:0] prev_odat, prev_bdat;

  always #2.5 clk = ~clk;

  ibl_link dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_flip(in_flip), .bus_valid(bus_valid),
    .bus_data(bus_data), .bus_ready(bus_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [7:0] wdata(int b, int k);
    return 8'(b * 8 + k);
  endfunction
  function automatic logic [7:0] fpat(int b);
    return 8'(b);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    out_ready = !((cyc % 7) == 3 || (cyc % 11) == 5);
    if (mon_en) begin
      if (prev_bstall) chk(bus_valid && bus_data == prev_bdat, "R8", int'(bus_data), int'(prev_bdat));
      if (prev_ostall) chk(out_valid && out_data == prev_odat, "R6", int'(out_data), int'(prev_odat));
      if (bus_valid && bus_ready) begin
        automatic int b = bi / 9;
        automatic int p = bi % 9;
        automatic logic [7:0] f = fpat(b);
        if (p == 8) chk(bus_data == f, "R2", int'(bus_data), int'(f));
        else chk(bus_data == (wdata(b, p) ^ {8{f[p]}}), "R1", int'(bus_data), int'(wdata(b, p) ^ {8{f[p]}}));
        bi++;
      end
      if (out_valid) begin
        chk(bi >= (oi / 8) * 9 + 9, "R5", bi, (oi / 8) * 9 + 9);
        if (out_ready) begin
          chk(out_data == wdata(oi / 8, oi % 8), "R4", int'(out_data), int'(wdata(oi / 8, oi % 8)));
          oi++;
        end
      end
    end
    prev_bstall = bus_valid && !bus_ready;
    prev_bdat   = bus_data;
    prev_ostall = out_valid && !out_ready;
    prev_odat   = out_data;
  end

  task automatic send(logic [7:0] d, logic f, int k);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_flip = f;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    if (k == 7) begin
      @(negedge clk);
      in_valid = 1'b0;
      chk(!in_ready, "R3", int'(in_ready), 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", oi, NW);
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready, "R7", int'(in_ready), 1);
    chk(!bus_valid, "R7", int'(bus_valid), 0);
    chk(!out_valid, "R7", int'(out_valid), 0);
    // partial burst, then reset mid-burst
    for (int k = 0; k < 5; k++) send(8'hA0 + 8'(k), k[0], k);
    @(negedge clk); in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(in_ready, "R7", int'(in_ready), 1);
    chk(!bus_valid, "R7", int'(bus_valid), 0);
    chk(!out_valid, "R7", int'(out_valid), 0);
    mon_en = 1'b1;
    repeat (20) @(negedge clk);
    chk(!out_valid && oi == 0, "R7", oi, 0);
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < 8; k++) begin
        automatic logic [7:0] f = fpat(b);
        send(wdata(b, k), f[k], k);
        if ((b % 3) == 0 && k == 3) begin
          @(negedge clk); in_valid = 1'b0;
          repeat (2) @(negedge clk);
        end
      end
    end
    @(negedge clk); in_valid = 1'b0;
    while (oi < NW) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(oi == NW, "R4", oi, NW);
    chk(bi == NB * 9, "R2", bi, NB * 9);
    done = 1'b1;
    summary();
  end
endmodule